// File: doc/BRIEF.md
# ATA Control-Block Register Interface

This block is the device-side logic for the two control-block registers of a parallel ATA disk interface. The host reaches them through a chip-select and a one-bit offset. The low offset (the 3F6h slot) is read as an alternate copy of the drive status byte and written as the device control byte. The high offset (the 3F7h slot) is read-only and returns a drive/head address byte in inverted form. The block never drives a pad itself. It produces data-out bits with a per-bit output enable, plus a data/enable pair for the interrupt request line, and the pad ring turns these into tri-state drivers.

The device control byte holds two controls. One is a soft-reset request, which the rest of the drive treats as a reset for both drives on the cable. The other is an active-low interrupt enable. The block also holds the pending-interrupt flag. An internal one-cycle event sets the flag. A one-cycle strobe, raised when the host reads the primary status register, clears it. The soft reset also clears it. Reading the alternate status leaves the flag as it is.

Top module: `ata_ctl_blk`

## Requirements
- R1: A read cycle (`cs_i` and `rd_i` high) at offset 0 returns `status_i` unchanged on `rdata_o`, with all eight bits of `rdata_oe_o` set.
- R2: An offset-0 read cycle does not change the pending-interrupt flag seen on `intrq_o`.
- R3: A read cycle at offset 1 returns this byte. Bit 7 reads 0 and its enable is never set. Bit 6 is `~wr_gate_i`. Bits 5..2 are `~head_i`, with bit 5 as the MSB. Bits 1..0 are the active-low selects of drive 1 and drive 0. `rdata_oe_o` is 8'h7F.
- R4: The select bit of drive k (bit k) reads 0 only when `drv_active_i` is 1 and `sel_drv_i` equals k. In every other case it reads 1.
- R5: Outside a read cycle, `rdata_o` and `rdata_oe_o` are both 8'h00.
- R6: A write cycle at offset 0 loads bit 1 into the interrupt disable and bit 2 into the soft-reset bit. Bits 7..3 and 0 are ignored. `srst_o` shows the new soft-reset bit from the clock edge that takes the write.
- R7: While `srst_o` is 1, the pending flag is cleared one edge later and held clear. Events that arrive during this time are dropped.
- R8: `irq_evt_i` sets the pending flag and `pri_stat_rd_i` clears it, each at the next edge. When both arrive in the same cycle, the set wins. `intrq_o` shows the flag.
- R9: `intrq_oe_o` is 1 exactly when the interrupt disable is 0 and `sel_drv_i` equals `this_drv_i`.
- R10: After `rst_ni` is asserted, the soft reset, the interrupt disable and the pending flag are all 0.
- R11: A write cycle at offset 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Control-block chip select |
| addr_i | input | 1 | Offset: 0 is status/control, 1 is drive address |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| status_i | input | 8 | Current drive status byte |
| head_i | input | 4 | Selected head number |
| wr_gate_i | input | 1 | Media write in progress |
| sel_drv_i | input | 1 | Drive number selected on the cable |
| this_drv_i | input | 1 | Drive number of this device |
| drv_active_i | input | 1 | Selected drive is active |
| irq_evt_i | input | 1 | One-cycle interrupt event |
| pri_stat_rd_i | input | 1 | One-cycle primary status read strobe |
| rdata_o | output | 8 | Read data |
| rdata_oe_o | output | 8 | Per-bit read data output enable |
| srst_o | output | 1 | Soft-reset request |
| intrq_o | output | 1 | Interrupt request level |
| intrq_oe_o | output | 1 | Interrupt request output enable |

## Verification
The assertions assume that `rd_i` and `wr_i` are never high together, since a host cycle is either a read or a write. They also assume that `irq_evt_i` and `pri_stat_rd_i` are single-cycle pulses from the core. The bench never raises both strobes at once. It drives each host access for exactly one clock, between falling edges. Event and status-read strobes are also one-cycle pulses, and they overlap only in the deliberate case that tests the set-over-clear priority.

// File: rtl/ata_ctl_pkg.sv
package ata_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int HEAD_W = 4;
  localparam int NDRV   = 2;
  localparam int SRST_BIT = 2;
  localparam int NIEN_BIT = 1;

  typedef enum logic {OFS_CTL = 1'b0, OFS_DADDR = 1'b1} ofs_e;

  typedef struct packed {
    logic alt_rd;
    logic daddr_rd;
    logic ctl_wr;
  } acc_t;
endpackage

// File: rtl/ata_ctl_decode.sv
module ata_ctl_decode
  import ata_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic addr_i,
  input  logic rd_i,
  input  logic wr_i,
  output acc_t acc_o
);
  always_comb begin
    acc_o          = '0;
    acc_o.alt_rd   = cs_i && rd_i && (addr_i == OFS_CTL);
    acc_o.daddr_rd = cs_i && rd_i && (addr_i == OFS_DADDR);
    acc_o.ctl_wr   = cs_i && wr_i && (addr_i == OFS_CTL);
  end

  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rd_i && wr_i)) |-> $onehot0(acc_o)); // R1
  AST_NO_DADDR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_DADDR) |-> !acc_o.ctl_wr); // R11
endmodule

// File: rtl/ata_drv_addr_fmt.sv
module ata_drv_addr_fmt
  import ata_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_gate_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic              sel_drv_i,
  input  logic              drv_active_i,
  output logic [DATA_W-1:0] byte_o
);
  localparam int HEAD_LSB = NDRV;
  localparam int WTG_BIT  = HEAD_LSB + HEAD_W;

  logic [NDRV-1:0] nds;

  for (genvar g = 0; g < NDRV; g++) begin : g_nds
    assign nds[g] = ~(drv_active_i && (sel_drv_i == g[0]));
  end

  always_comb begin
    byte_o                           = '0;
    byte_o[NDRV-1:0]                 = nds;
    byte_o[WTG_BIT-1:HEAD_LSB]       = ~head_i;
    byte_o[WTG_BIT]                  = ~wr_gate_i;
  end

  AST_IDLE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_active_i |-> (byte_o[NDRV-1:0] == '1)); // R4
  AST_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~byte_o[NDRV-1:0]) <= 1); // R4
endmodule

// File: rtl/ata_dev_ctl_reg.sv
module ata_dev_ctl_reg
  import ata_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              alt_rd_i,
  input  logic              irq_evt_i,
  input  logic              pri_stat_rd_i,
  input  logic              sel_match_i,
  output logic              srst_o,
  output logic              pend_o,
  output logic              intrq_oe_o
);
  logic srst_q, nien_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0;
      nien_q <= 1'b0;
    end else if (ctl_wr_i) begin
      srst_q <= wdata_i[SRST_BIT];
      nien_q <= wdata_i[NIEN_BIT];
    end
  end

  // set beats clear so a coincident event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pend_q <= 1'b0;
    else if (srst_q)        pend_q <= 1'b0;
    else if (irq_evt_i)     pend_q <= 1'b1;
    else if (pri_stat_rd_i) pend_q <= 1'b0;
  end

  assign srst_o     = srst_q;
  assign pend_o     = pend_q;
  assign intrq_oe_o = !nien_q && sel_match_i;

  AST_ALT_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_rd_i && pend_q && !srst_q && !pri_stat_rd_i) |=> pend_q); // R2
  AST_SRST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i |=> (srst_o == $past(wdata_i[SRST_BIT]))); // R6
  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> !pend_o); // R7
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_evt_i && !srst_q) |=> pend_o); // R8
  AST_NIEN_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && wdata_i[NIEN_BIT]) |=> !intrq_oe_o); // R9
endmodule

// File: rtl/ata_ctl_blk.sv
module ata_ctl_blk
  import ata_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic              wr_gate_i,
  input  logic              sel_drv_i,
  input  logic              this_drv_i,
  input  logic              drv_active_i,
  input  logic              irq_evt_i,
  input  logic              pri_stat_rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] rdata_oe_o,
  output logic              srst_o,
  output logic              intrq_o,
  output logic              intrq_oe_o
);
  localparam logic [DATA_W-1:0] DADDR_OE = {1'b0, {(DATA_W-1){1'b1}}};

  acc_t              acc;
  logic [DATA_W-1:0] daddr_byte;

  ata_ctl_decode u_dec (
    .clk_i (clk_i), .rst_ni (rst_ni), .cs_i (cs_i), .addr_i (addr_i),
    .rd_i (rd_i), .wr_i (wr_i), .acc_o (acc)
  );

  ata_drv_addr_fmt u_fmt (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_gate_i (wr_gate_i),
    .head_i (head_i), .sel_drv_i (sel_drv_i),
    .drv_active_i (drv_active_i), .byte_o (daddr_byte)
  );

  ata_dev_ctl_reg u_ctl (
    .clk_i (clk_i), .rst_ni (rst_ni), .ctl_wr_i (acc.ctl_wr),
    .wdata_i (wdata_i), .alt_rd_i (acc.alt_rd), .irq_evt_i (irq_evt_i),
    .pri_stat_rd_i (pri_stat_rd_i), .sel_match_i (sel_drv_i == this_drv_i),
    .srst_o (srst_o), .pend_o (intrq_o), .intrq_oe_o (intrq_oe_o)
  );

  always_comb begin
    rdata_o    = '0;
    rdata_oe_o = '0;
    if (acc.alt_rd) begin
      rdata_o    = status_i;
      rdata_oe_o = '1;
    end else if (acc.daddr_rd) begin
      rdata_o    = daddr_byte;
      rdata_oe_o = DADDR_OE;
    end
  end

  AST_B7_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_DADDR) |-> !rdata_oe_o[DATA_W-1]); // R3
  AST_OE_ONLY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_oe_o != '0) |-> (cs_i && rd_i)); // R5
  AST_OE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intrq_oe_o |-> (sel_drv_i == this_drv_i)); // R9
endmodule

// File: tb/ata_ctl_blk_bench.sv
module ata_ctl_blk_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 0, addr_i = 0, rd_i = 0, wr_i = 0;
  logic [7:0] wdata_i = 0, status_i = 0;
  logic [3:0] head_i = 0;
  logic wr_gate_i = 0, sel_drv_i = 0, this_drv_i = 0, drv_active_i = 0;
  logic irq_evt_i = 0, pri_stat_rd_i = 0;
  logic [7:0] rdata_o, rdata_oe_o;
  logic srst_o, intrq_o, intrq_oe_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ata_ctl_blk u_ata_ctl_blk (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 0; wr_i = 0;
  endtask

  task automatic pulse(input logic evt, input logic prd);
    @(negedge clk_i);
    irq_evt_i = evt; pri_stat_rd_i = prd;
    @(negedge clk_i);
    irq_evt_i = 0; pri_stat_rd_i = 0;
  endtask

  task automatic host_rd(input logic a, output logic [7:0] d, output logic [7:0] oe);
    @(negedge clk_i);
    cs_i = 1; rd_i = 1; addr_i = a;
    #1 d = rdata_o; oe = rdata_oe_o;
    @(negedge clk_i);
    cs_i = 0; rd_i = 0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R10 srst", {7'd0, srst_o}, 8'd0);
    chk("R10 pend", {7'd0, intrq_o}, 8'd0);
    chk("R10 nien", {7'd0, intrq_oe_o}, 8'd1);
    chk("R5 oe idle", rdata_oe_o, 8'h00);
    chk("R5 data idle", rdata_o, 8'h00);
  endtask

  task automatic t_alt_status();
    logic [7:0] d, oe;
    status_i = 8'hA5;
    host_rd(1'b0, d, oe);
    chk("R1 data", d, 8'hA5);
    chk("R1 oe", oe, 8'hFF);
    status_i = 8'h5A;
    host_rd(1'b0, d, oe);
    chk("R1 data2", d, 8'h5A);
  endtask

  task automatic t_daddr();
    logic [7:0] d, oe;
    head_i = 4'd3; wr_gate_i = 0; sel_drv_i = 0; drv_active_i = 1;
    host_rd(1'b1, d, oe);
    chk("R3 byte head3", d, 8'h72);
    chk("R3 oe", oe, 8'h7F);
    head_i = 4'd9; wr_gate_i = 1; sel_drv_i = 1;
    host_rd(1'b1, d, oe);
    chk("R4 drive1 sel", d, 8'h19);
    head_i = 4'd0; wr_gate_i = 0; drv_active_i = 0;
    host_rd(1'b1, d, oe);
    chk("R4 inactive", d, 8'h7F);
    sel_drv_i = 0;
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    cs_i = 0; rd_i = 1; addr_i = 0; status_i = 8'hFF;
    #1 chk("R5 no cs", rdata_oe_o, 8'h00);
    @(negedge clk_i);
    rd_i = 0;
  endtask

  task automatic t_pend();
    logic [7:0] d, oe;
    pulse(1, 0);
    chk("R8 set", {7'd0, intrq_o}, 8'd1);
    host_rd(1'b0, d, oe);
    chk("R2 alt keeps", {7'd0, intrq_o}, 8'd1);
    pulse(0, 1);
    chk("R8 clear", {7'd0, intrq_o}, 8'd0);
    pulse(1, 1);
    chk("R8 set wins", {7'd0, intrq_o}, 8'd1);
    pulse(0, 1);
    chk("R8 clear2", {7'd0, intrq_o}, 8'd0);
  endtask

  task automatic t_nien();
    host_wr(1'b0, 8'h02);
    chk("R9 disabled", {7'd0, intrq_oe_o}, 8'd0);
    host_wr(1'b0, 8'h00);
    chk("R9 enabled", {7'd0, intrq_oe_o}, 8'd1);
    @(negedge clk_i);
    sel_drv_i = 1;
    #1 chk("R9 other drive", {7'd0, intrq_oe_o}, 8'd0);
    this_drv_i = 1;
    #1 chk("R9 this drive1", {7'd0, intrq_oe_o}, 8'd1);
    sel_drv_i = 0; this_drv_i = 0;
  endtask

  task automatic t_srst();
    pulse(1, 0);
    host_wr(1'b0, 8'h04);
    chk("R6 srst set", {7'd0, srst_o}, 8'd1);
    @(negedge clk_i);
    chk("R7 pend cleared", {7'd0, intrq_o}, 8'd0);
    pulse(1, 0);
    chk("R7 evt dropped", {7'd0, intrq_o}, 8'd0);
    host_wr(1'b0, 8'h00);
    chk("R6 srst off", {7'd0, srst_o}, 8'd0);
    host_wr(1'b0, 8'hF9);
    chk("R6 upper ignored srst", {7'd0, srst_o}, 8'd0);
    chk("R6 upper ignored nien", {7'd0, intrq_oe_o}, 8'd1);
    host_wr(1'b1, 8'h06);
    chk("R11 srst", {7'd0, srst_o}, 8'd0);
    chk("R11 nien", {7'd0, intrq_oe_o}, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_alt_status();
    t_daddr();
    t_idle();
    t_pend();
    t_nien();
    t_srst();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule